// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block lets a processor reach a configuration space through two registers on its own side. The first is a 32-bit address latch that software loads with the target location. The second is a data window: a byte, halfword or word read or write to the window becomes one configuration request on the downstream side. The window only forwards an access when the top bit of the latch is set. With that bit clear, window writes vanish and window reads return all ones sized to the access.

For sub-word accesses, the two low bits of the window access address select the byte lane. They are ORed into the latched address before the request goes out. Word writes carry the latched address unchanged. The downstream side uses a valid/ready request handshake. A separate read-valid strobe returns read data, and the host access stays busy until the request finishes. A build parameter lets halfword and word data cross the bridge byte-reversed, for hosts whose byte order is big-endian.

Top module: `cfg_port_bridge`

## Requirements
- R1: An access with `host_port`=1 reaches the address latch: a write stores all 32 bits of `host_wdata`, and a read returns the stored value on `host_rdata`. The latch is 0 after reset, only latch writes change it, and the access completes with `host_done` one cycle after the request.
- R2: While latch bit 31 is 0, a window write (`host_port`=0) raises no `cfg_valid` and changes no configuration data. It completes with `host_done` one cycle after the request and leaves the latch unchanged.
- R3: While latch bit 31 is 0, a window read raises no `cfg_valid` and completes one cycle after the request. It returns 0x000000FF for a byte, 0x0000FFFF for a halfword and 0xFFFFFFFF for a word.
- R4: With bit 31 set, a byte or halfword window write sends `cfg_addr` = latch OR `host_off`.
- R5: With bit 31 set, a word window write sends `cfg_addr` equal to the latch, and `host_off` has no effect on it.
- R6: With bit 31 set, a window read of any size sends `cfg_addr` = latch OR `host_off`.
- R7: `host_size` 0, 1 and 2 mean byte, halfword and word, and 3 is treated as word. Each request carries `cfg_size` 1, 2 or 4 and `cfg_we` equal to the host direction. `cfg_wdata` holds the low 1, 2 or 4 bytes of the (possibly swapped) host data, with the upper lanes zero.
- R8: `cfg_valid` rises in the cycle after the request. It stays high, with address, size, direction and data unchanged, until a cycle with `cfg_ready` high. A write completes with `host_done` in the cycle after acceptance. A read completes in the cycle after `cfg_rvalid`. `host_busy` is high from the request until completion.
- R9: Window read data is the low 1, 2 or 4 bytes of `cfg_rdata`, with the upper lanes of `host_rdata` zero.
- R10: With `BYTE_SWAP`=1, halfword data has its two bytes exchanged and word data has all four bytes reversed, on both the write and the read path. Byte data is never reordered. With `BYTE_SWAP`=0, no data is reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access request, taken when not busy |
| host_port | input | 1 | 1 selects the address latch, 0 the data window |
| host_we | input | 1 | 1 write, 0 read |
| host_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| host_off | input | 2 | Low bits of the window access address |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| cfg_valid | output | 1 | Downstream request valid |
| cfg_ready | input | 1 | Downstream request accepted |
| cfg_we | output | 1 | Downstream request is a write |
| cfg_addr | output | 32 | Downstream configuration address |
| cfg_size | output | 3 | Downstream size in bytes: 1, 2 or 4 |
| cfg_wdata | output | 32 | Downstream write data, right-aligned |
| cfg_rvalid | input | 1 | Downstream read data valid |
| cfg_rdata | input | 32 | Downstream read data, right-aligned |

## Verification
Two instances, one with swapping and one without, receive the same access sequence, each against its own byte-wide configuration memory. The sequence first runs every access size with the latch enable clear and then with it set. This separates the gating and the size-matched all-ones from the forwarding paths. Byte reads at all four offsets, halfword reads at offsets 0 and 2, and a word write with a nonzero offset show whether the offset is merged for sub-word accesses only. Distinct byte values in the memory expose any lane that is reversed, masked or swapped where it should not be. A dropped write, followed by a read-back after the enable is set again, confirms that the gated write left the configuration data untouched.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_RDWAIT = 2'd2
  } win_state_e;

  // host size code to byte count; code 3 is handled as a word
  function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch #(
  parameter int ADDR_W = 32,
  parameter int EN_BIT = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] q,
  output logic              enabled
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data;
  end

  assign enabled = q[EN_BIT];

  // R1: only a latch write moves the stored address
  p_latch_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/cfg_lane_mask.sv
module cfg_lane_mask #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  import cfg_bridge_pkg::*;

  localparam int NB = DATA_W / 8;

  logic [2:0] nbytes;
  assign nbytes = size_to_bytes(size);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign dout[8*i +: 8] = (i < int'(nbytes)) ? din[8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/cfg_lane_swap.sv
module cfg_lane_swap #(
  parameter int DATA_W = 32,
  parameter int SWAP   = 0
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  import cfg_bridge_pkg::*;

  localparam int NB = DATA_W / 8;

  if (SWAP != 0) begin : g_swap
    logic [DATA_W-1:0] word_rev;
    logic [DATA_W-1:0] half_rev;

    for (genvar i = 0; i < NB; i++) begin : g_rev
      assign word_rev[8*i +: 8] = din[8*(NB-1-i) +: 8];
    end

    assign half_rev = {din[DATA_W-1:16], din[7:0], din[15:8]};

    always_comb begin
      case (size)
        SZ_BYTE: dout = din;
        SZ_HALF: dout = half_rev;
        default: dout = word_rev;
      endcase
    end
  end else begin : g_pass
    assign dout = din;
  end

endmodule

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int EN_BIT = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_port,
  input  logic              host_we,
  input  logic [1:0]        host_size,
  input  logic [1:0]        host_off,
  input  logic [DATA_W-1:0] wr_prep,
  input  logic [DATA_W-1:0] rd_prep,
  input  logic [ADDR_W-1:0] latch_q,
  input  logic              latch_en,
  input  logic              cfg_ready,
  input  logic              cfg_rvalid,
  output logic              latch_wr,
  output logic              cfg_valid,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [2:0]        cfg_size,
  output logic [DATA_W-1:0] cfg_wdata,
  output logic [1:0]        held_size,
  output logic              host_busy,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata
);
  import cfg_bridge_pkg::*;

  localparam logic [DATA_W-1:0] ONES_B = {{(DATA_W-8){1'b0}}, 8'hFF};
  localparam logic [DATA_W-1:0] ONES_H = {{(DATA_W-16){1'b0}}, 16'hFFFF};
  localparam logic [DATA_W-1:0] ONES_W = '1;

  win_state_e st;
  logic       start;
  logic       word_wr;
  logic [ADDR_W-1:0] merged;

  assign start     = host_req && (st == ST_IDLE);
  assign latch_wr  = start && host_port && host_we;
  assign host_busy = (st != ST_IDLE);
  assign word_wr   = host_we && (size_to_bytes(host_size) == 3'd4);
  assign merged    = latch_q | {{(ADDR_W-2){1'b0}}, host_off};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cfg_valid  <= 1'b0;
      cfg_we     <= 1'b0;
      cfg_addr   <= '0;
      cfg_size   <= 3'd0;
      cfg_wdata  <= '0;
      held_size  <= SZ_BYTE;
      host_done  <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (host_port) begin
              host_done  <= 1'b1;
              host_rdata <= host_we ? '0 : DATA_W'(latch_q);
            end else if (!latch_en) begin
              host_done <= 1'b1;
              if (host_we) host_rdata <= '0;
              else begin
                case (host_size)
                  SZ_BYTE: host_rdata <= ONES_B;
                  SZ_HALF: host_rdata <= ONES_H;
                  default: host_rdata <= ONES_W;
                endcase
              end
            end else begin
              cfg_valid <= 1'b1;
              cfg_we    <= host_we;
              cfg_addr  <= word_wr ? latch_q : merged;
              cfg_size  <= size_to_bytes(host_size);
              cfg_wdata <= host_we ? wr_prep : '0;
              held_size <= host_size;
              st        <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (cfg_ready) begin
            cfg_valid <= 1'b0;
            if (cfg_we) begin
              host_done  <= 1'b1;
              host_rdata <= '0;
              st         <= ST_IDLE;
            end else begin
              st <= ST_RDWAIT;
            end
          end
        end
        ST_RDWAIT: begin
          if (cfg_rvalid) begin
            host_done  <= 1'b1;
            host_rdata <= rd_prep;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: request fields hold until accepted
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_size)
                                && $stable(cfg_we) && $stable(cfg_wdata));

  // R8: an outstanding request keeps the host side busy
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> host_busy);

  // R2: nothing leaves while the enable bit is clear
  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> latch_en);

  // R7: only legal byte counts go downstream
  p_size_legal_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_size == 3'd1 || cfg_size == 3'd2 || cfg_size == 3'd4));

  // R7: a byte write leaves the upper lanes clear
  p_byte_lanes_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && cfg_we && cfg_size == 3'd1 |-> cfg_wdata[DATA_W-1:8] == '0);

  // R5: word writes use the latch untouched
  p_word_addr_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && cfg_we && cfg_size == 3'd4 |-> cfg_addr == latch_q);

  // R4: sub-word writes differ from the latch only in the two low bits
  p_sub_addr_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_valid && cfg_we && cfg_size != 3'd4 |-> cfg_addr[ADDR_W-1:2] == latch_q[ADDR_W-1:2]);

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BYTE_SWAP = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_port,
  input  logic              host_we,
  input  logic [1:0]        host_size,
  input  logic [1:0]        host_off,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_busy,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [2:0]        cfg_size,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_rvalid,
  input  logic [DATA_W-1:0] cfg_rdata
);

  localparam int EN_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] latch_q;
  logic              latch_en;
  logic              latch_wr;
  logic [1:0]        held_size;
  logic [DATA_W-1:0] wr_masked, wr_prep;
  logic [DATA_W-1:0] rd_masked, rd_prep;

  cfg_addr_latch #(.ADDR_W(ADDR_W), .EN_BIT(EN_BIT)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (latch_wr),
    .wr_data (ADDR_W'(host_wdata)),
    .q       (latch_q),
    .enabled (latch_en)
  );

  cfg_lane_mask #(.DATA_W(DATA_W)) u_wr_mask (
    .size (host_size),
    .din  (host_wdata),
    .dout (wr_masked)
  );

  cfg_lane_swap #(.DATA_W(DATA_W), .SWAP(BYTE_SWAP)) u_wr_swap (
    .size (host_size),
    .din  (wr_masked),
    .dout (wr_prep)
  );

  cfg_lane_mask #(.DATA_W(DATA_W)) u_rd_mask (
    .size (held_size),
    .din  (cfg_rdata),
    .dout (rd_masked)
  );

  cfg_lane_swap #(.DATA_W(DATA_W), .SWAP(BYTE_SWAP)) u_rd_swap (
    .size (held_size),
    .din  (rd_masked),
    .dout (rd_prep)
  );

  cfg_window_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_port  (host_port),
    .host_we    (host_we),
    .host_size  (host_size),
    .host_off   (host_off),
    .wr_prep    (wr_prep),
    .rd_prep    (rd_prep),
    .latch_q    (latch_q),
    .latch_en   (latch_en),
    .cfg_ready  (cfg_ready),
    .cfg_rvalid (cfg_rvalid),
    .latch_wr   (latch_wr),
    .cfg_valid  (cfg_valid),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_size   (cfg_size),
    .cfg_wdata  (cfg_wdata),
    .held_size  (held_size),
    .host_busy  (host_busy),
    .host_done  (host_done),
    .host_rdata (host_rdata)
  );

endmodule

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_port = 1'b0, host_we = 1'b0;
  logic [1:0]  host_size = 2'd0, host_off = 2'd0;
  logic [31:0] host_wdata = '0;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // instance 0 without swap, instance 1 with swap (R10)
  for (genvar g = 0; g < 2; g++) begin : g_dut
    logic        host_busy, host_done, cfg_valid, cfg_ready, cfg_we, cfg_rvalid;
    logic [31:0] host_rdata, cfg_addr, cfg_wdata, cfg_rdata;
    logic [2:0]  cfg_size;
    logic [7:0]  mem [64];
    logic [1:0]  cnt;
    logic [5:0]  a;
    assign a = cfg_addr[5:0];

    cfg_port_bridge #(.ADDR_W(32), .DATA_W(32), .BYTE_SWAP(g)) i_cfg_port_bridge (
      .clk(clk), .rst(rst), .host_req(host_req), .host_port(host_port),
      .host_we(host_we), .host_size(host_size), .host_off(host_off),
      .host_wdata(host_wdata), .host_busy(host_busy), .host_done(host_done),
      .host_rdata(host_rdata), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
      .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata));

    // configuration space model: ready one cycle late, read data two cycles after accept
    always @(posedge clk) begin
      if (rst) begin
        cfg_ready  <= 1'b0;
        cfg_rvalid <= 1'b0;
        cfg_rdata  <= '0;
        cnt        <= 2'd0;
        for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
      end else begin
        cfg_ready  <= cfg_valid && !cfg_ready;
        cfg_rvalid <= 1'b0;
        if (cnt != 2'd0) begin
          cnt <= cnt - 2'd1;
          if (cnt == 2'd1) cfg_rvalid <= 1'b1;
        end
        if (cfg_valid && cfg_ready) begin
          if (cfg_we) begin
            for (int k = 0; k < 4; k++)
              if (k < int'(cfg_size)) mem[6'(a + 6'(k))] <= cfg_wdata[8*k +: 8];
          end else begin
            cfg_rdata <= {mem[6'(a + 6'd3)], mem[6'(a + 6'd2)], mem[6'(a + 6'd1)], mem[a]};
            cnt <= 2'd2;
          end
        end
      end
    end
  end

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  size;
    logic        we;
    logic [31:0] wd0;
    logic [31:0] wd1;
    logic [7:0]  rid;
  } req_t;

  typedef struct packed {
    logic [31:0] rd0;
    logic [31:0] rd1;
    logic [7:0]  rid;
    logic        swp;
  } rsp_t;

  req_t req_q[$];
  rsp_t rsp_q[$];
  logic [31:0] lat_model = '0;
  logic [7:0]  sh [2][64];

  task automatic chk(input bit ok, input int rid, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rid, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fmask(input logic [31:0] v, input int n);
    if (n == 1) return {24'h0, v[7:0]};
    if (n == 2) return {16'h0, v[15:0]};
    return v;
  endfunction

  function automatic logic [31:0] fswap(input logic [31:0] v, input int n);
    if (n == 1) return v;
    if (n == 2) return {16'h0, v[7:0], v[15:8]};
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // driver: predicts the outcome, queues it, then runs the host access
  task automatic access(input bit port, input bit we, input logic [1:0] sz,
                        input logic [1:0] off, input logic [31:0] wd);
    int   n, elat, lat;
    req_t q;
    rsp_t r;
    logic [31:0] raw0, raw1, w1;
    logic [5:0]  ad;
    bit   fwd;
    n    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;   // R7: code 3 as word
    fwd  = 1'b0;
    r    = '0;
    q    = '0;
    if (port) begin                       // R1
      elat  = 1;
      r.rid = 8'd1;
      r.rd0 = we ? 32'h0 : lat_model;
      r.rd1 = r.rd0;
      if (we) lat_model = wd;
    end else if (!lat_model[31]) begin    // R2 / R3
      elat  = 1;
      r.rid = we ? 8'd2 : 8'd3;
      r.rd0 = we ? 32'h0 : fmask(32'hFFFF_FFFF, n);
      r.rd1 = r.rd0;
    end else begin
      fwd    = 1'b1;
      q.size = 3'(n);
      q.we   = we;
      if (we) begin                       // R4 / R5 / R7 / R10
        q.addr = (n == 4) ? lat_model : (lat_model | {30'h0, off});
        q.wd0  = fmask(wd, n);
        q.wd1  = fswap(q.wd0, n);
        q.rid  = (n == 4) ? 8'd5 : 8'd4;
        ad     = q.addr[5:0];
        for (int k = 0; k < n; k++) begin
          sh[0][6'(ad + 6'(k))] = q.wd0[8*k +: 8];
          sh[1][6'(ad + 6'(k))] = q.wd1[8*k +: 8];
        end
        elat   = 3;
        r.rid  = 8'd8;
      end else begin                      // R6 / R9 / R10
        q.addr = lat_model | {30'h0, off};
        q.rid  = 8'd6;
        ad     = q.addr[5:0];
        raw0   = {sh[0][6'(ad + 6'd3)], sh[0][6'(ad + 6'd2)], sh[0][6'(ad + 6'd1)], sh[0][ad]};
        raw1   = {sh[1][6'(ad + 6'd3)], sh[1][6'(ad + 6'd2)], sh[1][6'(ad + 6'd1)], sh[1][ad]};
        r.rd0  = fmask(raw0, n);
        w1     = fmask(raw1, n);
        r.rd1  = fswap(w1, n);
        r.rid  = 8'd9;
        r.swp  = (n > 1);
        elat   = 6;
      end
      req_q.push_back(q);
    end
    rsp_q.push_back(r);
    host_port  = port;
    host_we    = we;
    host_size  = sz;
    host_off   = off;
    host_wdata = wd;
    host_req   = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    lat = 1;
    if (fwd) chk(g_dut[0].host_busy && g_dut[1].host_busy, 8, "busy during request",
                 {31'h0, g_dut[0].host_busy}, 32'h1);
    while (!g_dut[0].host_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == elat, 8, "completion latency", 32'(lat), 32'(elat));   // R8
    @(negedge clk);
  endtask

  // monitor: compares requests and results against the queued predictions
  always @(negedge clk) begin
    if (!rst) begin
      if ((g_dut[0].cfg_valid || g_dut[1].cfg_valid) && req_q.size() == 0)
        chk(1'b0, 2, "request without a forwarded access", 32'h1, 32'h0);
      if (g_dut[0].cfg_valid && g_dut[0].cfg_ready && req_q.size() != 0) begin
        req_t e;
        e = req_q.pop_front();
        chk(g_dut[1].cfg_valid && g_dut[1].cfg_ready, 8, "both instances accept",
            {31'h0, g_dut[1].cfg_ready}, 32'h1);
        chk(g_dut[0].cfg_addr == e.addr, int'(e.rid), "cfg_addr", g_dut[0].cfg_addr, e.addr);
        chk(g_dut[1].cfg_addr == e.addr, int'(e.rid), "cfg_addr swap inst", g_dut[1].cfg_addr, e.addr);
        chk(g_dut[0].cfg_size == e.size, 7, "cfg_size", 32'(g_dut[0].cfg_size), 32'(e.size));
        chk(g_dut[0].cfg_we == e.we, 7, "cfg_we", 32'(g_dut[0].cfg_we), 32'(e.we));
        if (e.we) begin
          chk(g_dut[0].cfg_wdata == e.wd0, 7, "cfg_wdata", g_dut[0].cfg_wdata, e.wd0);
          chk(g_dut[1].cfg_wdata == e.wd1, (e.size > 3'd1) ? 10 : 7, "cfg_wdata swap inst",
              g_dut[1].cfg_wdata, e.wd1);
        end
      end
      if (g_dut[0].host_done) begin
        if (rsp_q.size() == 0) chk(1'b0, 8, "unexpected completion", 32'h1, 32'h0);
        else begin
          rsp_t r;
          r = rsp_q.pop_front();
          chk(g_dut[1].host_done, 8, "both instances complete", {31'h0, g_dut[1].host_done}, 32'h1);
          chk(g_dut[0].host_rdata == r.rd0, int'(r.rid), "host_rdata", g_dut[0].host_rdata, r.rd0);
          chk(g_dut[1].host_rdata == r.rd1, r.swp ? 10 : int'(r.rid), "host_rdata swap inst",
              g_dut[1].host_rdata, r.rd1);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      sh[0][i] = 8'(i * 7 + 3);
      sh[1][i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!g_dut[0].host_busy && !g_dut[0].cfg_valid && !g_dut[0].host_done, 1,
        "idle after reset", {29'h0, g_dut[0].host_busy, g_dut[0].cfg_valid, g_dut[0].host_done}, 32'h0);
    access(1'b1, 1'b0, 2'd2, 2'd0, 32'h0);             // R1 latch reads zero
    access(1'b0, 1'b1, 2'd0, 2'd1, 32'h0000_0011);     // R2 dropped byte write
    access(1'b0, 1'b1, 2'd2, 2'd0, 32'hDEAD_BEEF);     // R2 dropped word write
    access(1'b1, 1'b0, 2'd2, 2'd0, 32'h0);             // R2 latch unchanged
    access(1'b0, 1'b0, 2'd0, 2'd0, 32'h0);             // R3 byte ones
    access(1'b0, 1'b0, 2'd1, 2'd2, 32'h0);             // R3 half ones
    access(1'b0, 1'b0, 2'd2, 2'd0, 32'h0);             // R3 word ones
    access(1'b1, 1'b1, 2'd2, 2'd0, 32'h0000_0013);     // R1 other bits, enable clear
    access(1'b0, 1'b0, 2'd1, 2'd1, 32'h0);             // R3 still gated
    access(1'b1, 1'b0, 2'd2, 2'd0, 32'h0);             // R1 read back
    access(1'b1, 1'b1, 2'd2, 2'd0, 32'h8000_0010);     // R1 enable
    access(1'b1, 1'b0, 2'd2, 2'd0, 32'h0);             // R1 read back
    access(1'b0, 1'b1, 2'd2, 2'd0, 32'h4433_2211);     // R5 word write
    access(1'b0, 1'b1, 2'd2, 2'd3, 32'hA1B2_C3D4);     // R5 offset ignored
    access(1'b0, 1'b1, 2'd0, 2'd1, 32'hFFFF_FF5A);     // R4 R7 byte write
    access(1'b0, 1'b1, 2'd1, 2'd2, 32'h1234_BEEF);     // R4 R10 half write
    for (int o = 0; o < 4; o++)
      access(1'b0, 1'b0, 2'd0, 2'(o), 32'h0);          // R6 R9 byte reads
    access(1'b0, 1'b0, 2'd1, 2'd0, 32'h0);             // R6 R10 half read
    access(1'b0, 1'b0, 2'd1, 2'd2, 32'h0);
    access(1'b0, 1'b0, 2'd2, 2'd0, 32'h0);             // R6 R10 word read
    access(1'b0, 1'b0, 2'd2, 2'd1, 32'h0);             // R6 word read, offset merged
    access(1'b1, 1'b1, 2'd2, 2'd0, 32'h8000_0020);
    access(1'b0, 1'b1, 2'd1, 2'd0, 32'h0000_CAFE);     // R4 half at offset 0
    access(1'b0, 1'b1, 2'd3, 2'd2, 32'h0102_0304);     // R7 code 3 as word, R5
    access(1'b0, 1'b0, 2'd3, 2'd0, 32'h0);             // R7 R9 word read
    access(1'b1, 1'b1, 2'd2, 2'd0, 32'h0000_0020);     // disable again
    access(1'b0, 1'b1, 2'd2, 2'd0, 32'hFFFF_FFFF);     // R2 dropped
    access(1'b0, 1'b0, 2'd2, 2'd0, 32'h0);             // R3
    access(1'b1, 1'b1, 2'd2, 2'd0, 32'h8000_0020);
    access(1'b0, 1'b0, 2'd2, 2'd0, 32'h0);             // R2 data untouched
    repeat (4) @(negedge clk);
    chk(req_q.size() == 0 && rsp_q.size() == 0, 8, "all predictions consumed",
        32'(req_q.size() + rsp_q.size()), 32'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL R8 watchdog expired: actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule